// File: doc/BRIEF.md
# Word-to-Byte Transmit Serializer

This block turns a 32-bit word into four bytes for an 8-bit byte sink such as a serial transmitter. A word producer offers its word through a valid/ready pair. The block registers the word once, when that handshake completes. It then presents the stored top byte on a second valid/ready pair towards the sink. After each byte the sink accepts, the stored copy moves left by eight bits, so the next byte always comes from the same top lane.

The control is a two-state machine with these states:

- `ST_IDLE`: the block is empty and offers `word_ready_o`.
- `ST_SEND`: the block offers bytes on `byte_valid_o`.

It has two transitions:

- accept: `ST_IDLE` to `ST_SEND`, taken when `word_valid_i` is high while the block is idle.
- drain: `ST_SEND` to `ST_IDLE`, taken on the handshake of the fourth byte.

A byte index counts the completed byte transfers from 0 to 4. It rests at 4 while the block is idle and is cleared to 0 when a word is accepted. The sink can hold `byte_ready_i` low for any number of cycles; the block waits and keeps the same byte on its output.

Top module: `word_byte_serializer`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) leaves the block idle, with `word_ready_o` = 1 and `byte_valid_o` = 0 in the following cycle.
- R2: `word_ready_o` is high exactly when the block is idle, and it is never high in the same cycle as `byte_valid_o`. A word is taken only at an edge where both `word_valid_i` and `word_ready_o` are high.
- R3: In the cycle after a word is accepted, `byte_valid_o` is 1 and `byte_data_o` carries bits 31..24 of the accepted word.
- R4: The bytes leave most significant first: bits 31..24, then 23..16, then 15..8, then 7..0. A byte moves on only at an edge where `byte_valid_o` and `byte_ready_i` are both high.
- R5: Each accepted word produces exactly four byte handshakes, and `byte_valid_o` is low in the cycle after the fourth handshake.
- R6: When `byte_valid_o` is 1 and `byte_ready_i` is 0 at an edge, the next cycle still shows `byte_valid_o` = 1 with the same `byte_data_o`.
- R7: Changes on `word_data_i` after a word has been accepted do not alter any byte of that word.
- R8: A `word_valid_i` raised while bytes are still being sent is ignored. `word_ready_o` stays 0 and no byte of that offered word appears.
- R9: `word_ready_o` is 1 in the cycle right after the fourth byte handshake, so a waiting word is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| word_valid_i | input | 1 | Producer offers a word |
| word_data_i | input | 32 | Word to serialize |
| word_ready_o | output | 1 | Block is idle and will take a word |
| byte_valid_o | output | 1 | A byte is presented to the sink |
| byte_data_o | output | 8 | Current byte (top lane of the stored word) |
| byte_ready_i | input | 1 | Sink accepts the presented byte |

## Verification
Every output comes from a register, so each result is due exactly one cycle after the edge that causes it:

- the first byte and `byte_valid_o` follow the word-accept edge by one cycle;
- each later byte follows its handshake edge by one cycle;
- `word_ready_o` returns one cycle after the fourth handshake;
- a stalled byte is shown again one cycle after the stall edge.

The bench keeps to this timing in three ways. It changes its inputs 2 ns after each rising edge. Its behavioural model, a byte queue and an idle flag, updates on the rising edge. It compares outputs with the model on the falling edge, when that cycle's result has settled. Directed checks count the falling edges after an accept or a stall to sample the one cycle the requirement names.

// File: rtl/ws_pkg.sv
package ws_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ws_state_e;

endpackage

// File: rtl/ws_ctrl.sv
module ws_ctrl
    import ws_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic word_valid_i,
    input  logic byte_ready_i,
    input  logic last_beat_i,
    output logic word_ready_o,
    output logic byte_valid_o,
    output logic load_o,
    output logic step_o
);

    ws_state_e state_q;
    ws_state_e state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept and drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (word_valid_i) state_d = ST_SEND;
            ST_SEND: if (byte_ready_i && last_beat_i) state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        word_ready_o = 1'b0;
        byte_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: word_ready_o = 1'b1;
            ST_SEND: byte_valid_o = 1'b1;
        endcase
        load_o = word_ready_o & word_valid_i;
        step_o = byte_valid_o & byte_ready_i;
    end

    // R2
    ready_valid_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(word_ready_o && byte_valid_o));

    // R3
    accept_then_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |=> byte_valid_o);

    // R9
    drain_then_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_o && last_beat_i) |=> (word_ready_o && !byte_valid_o));

endmodule

// File: rtl/ws_count.sv
module ws_count #(
    parameter int NBYTES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] IDX_DONE = CNT_W'(NBYTES);
    localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(NBYTES - 1);

    logic [CNT_W-1:0] idx_q;

    // the index rests at NBYTES while idle
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx_q <= IDX_DONE;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (step_i && idx_q != IDX_DONE) begin
            idx_q <= idx_q + CNT_W'(1);
        end
    end

    assign last_o = (idx_q == IDX_LAST);

    // R5
    idx_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        idx_q <= IDX_DONE);

    // R5
    idx_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && last_o) |=> (idx_q == IDX_DONE));

endmodule

// File: rtl/ws_shreg.sv
module ws_shreg #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [BYTE_W-1:0] top_o
);

    localparam int KEEP_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] store_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            store_q <= '0;
        end else if (load_i) begin
            store_q <= word_i;
        end else if (shift_i) begin
            store_q <= {store_q[KEEP_W-1:0], {BYTE_W{1'b0}}};
        end
    end

    assign top_o = store_q[WORD_W-1 -: BYTE_W];

endmodule

// File: rtl/word_byte_serializer.sv
module word_byte_serializer #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    input  logic              byte_ready_i
);

    localparam int NBYTES = WORD_W / BYTE_W;

    logic load_w;
    logic step_w;
    logic last_w;

    ws_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .word_valid_i (word_valid_i),
        .byte_ready_i (byte_ready_i),
        .last_beat_i  (last_w),
        .word_ready_o (word_ready_o),
        .byte_valid_o (byte_valid_o),
        .load_o       (load_w),
        .step_o       (step_w)
    );

    ws_count #(.NBYTES(NBYTES)) u_count (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (load_w),
        .step_i  (step_w),
        .last_o  (last_w)
    );

    ws_shreg #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_shreg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load_w),
        .shift_i (step_w),
        .word_i  (word_data_i),
        .top_o   (byte_data_o)
    );

    // R6
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

    // R8
    busy_ignore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_valid_o && !(byte_ready_i && last_w)) |=> !word_ready_o);

endmodule

// File: tb/word_byte_serializer_bench.sv
module word_byte_serializer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        byte_ready = 1'b0;
    logic        word_ready;
    logic        byte_valid;
    logic [7:0]  byte_data;

    always #10 clk = ~clk;

    word_byte_serializer u_word_byte_serializer (
        .clk_i        (clk),
        .rst_i        (rst),
        .word_valid_i (word_valid),
        .word_data_i  (word_data),
        .word_ready_o (word_ready),
        .byte_valid_o (byte_valid),
        .byte_data_o  (byte_data),
        .byte_ready_i (byte_ready)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    string phase_tag = "R4 byte order";
    bit    checking = 1'b0;
    int    ready_mode = 1;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model: idle flag and queue of pending bytes
    bit         m_idle = 1'b1;
    bit         m_done = 1'b0;
    logic [7:0] m_q[$];

    always @(posedge clk) begin
        m_done = 1'b0;
        if (rst) begin
            m_idle = 1'b1;
            m_q.delete();
        end else if (m_idle) begin
            if (word_valid) begin
                for (int k = 0; k < 4; k++) m_q.push_back(word_data[31-8*k -: 8]);
                m_idle = 1'b0;
            end
        end else if (byte_ready) begin
            logic [7:0] gone;
            gone = m_q.pop_front();
            if (m_q.size() == 0) begin
                m_idle = 1'b1;
                m_done = 1'b1;
            end
        end
    end

    // sink ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #2;
        case (ready_mode)
            0:       byte_ready = 1'b0;
            1:       byte_ready = 1'b1;
            default: byte_ready = 1'($urandom % 2);
        endcase
    end

    // per-cycle comparison on the falling edge
    int hs_cnt = 0;
    bit prev_busy = 1'b0;
    always @(negedge clk) begin
        if (checking && !rst) begin
            check(word_ready === m_idle, "R2 word_ready vs model", 32'(word_ready), 32'(m_idle));
            check(byte_valid === !m_idle, "R5 byte_valid vs model", 32'(byte_valid), 32'(!m_idle));
            if (!m_idle)
                check(byte_data === m_q[0], phase_tag, 32'(byte_data), 32'(m_q[0]));
            if (m_done)
                check(word_ready === 1'b1, "R9 ready after fourth byte", 32'(word_ready), 32'd1);
            if (prev_busy && word_ready) begin
                check(hs_cnt == 4, "R5 four bytes per word", 32'(hs_cnt), 32'd4);
                hs_cnt = 0;
            end
            if (byte_valid && byte_ready) hs_cnt++;
            prev_busy = byte_valid;
        end
    end

    task automatic send_word(input logic [31:0] w);
        word_valid = 1'b1;
        word_data  = w;
        do @(negedge clk); while (!word_ready);
        @(posedge clk);
        #2;
        word_valid = 1'b0;
        word_data  = ~w;
        @(negedge clk);
        check(byte_valid === 1'b1 && byte_data === w[31:24], "R3 first byte after accept",
              {23'h0, byte_valid, byte_data}, {23'h0, 1'b1, w[31:24]});
    endtask

    task automatic wait_idle();
        while (!word_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(word_ready === 1'b1, "R1 word_ready after reset", 32'(word_ready), 32'd1);
        check(byte_valid === 1'b0, "R1 byte_valid after reset", 32'(byte_valid), 32'd0);
        checking = 1'b1;

        // R3, R4: free-flowing sink
        ready_mode = 1;
        phase_tag  = "R4 byte order";
        send_word(32'hA1B2C3D4);
        wait_idle();

        // R6: sink stalls
        ready_mode = 0;
        phase_tag  = "R6 stalled byte";
        @(posedge clk);
        #2;
        send_word(32'h11223344);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(byte_valid === 1'b1 && byte_data === 8'h11, "R6 byte held under stall",
                  {23'h0, byte_valid, byte_data}, {23'h0, 1'b1, 8'h11});
        end
        ready_mode = 1;
        wait_idle();

        // R7: input word changes during transfer
        ready_mode = 2;
        phase_tag  = "R7 bytes unaffected by input change";
        send_word(32'hDEADBEEF);
        while (!word_ready) begin
            @(posedge clk);
            #2;
            word_data = $urandom;
            @(negedge clk);
        end

        // R8: word offered while busy
        ready_mode = 1;
        phase_tag  = "R8 busy offer ignored";
        @(posedge clk);
        #2;
        send_word(32'h0F1E2D3C);
        @(posedge clk);
        #2;
        word_valid = 1'b1;
        word_data  = 32'h55AA55AA;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(word_ready === 1'b0, "R8 ready low while busy", 32'(word_ready), 32'd0);
        end
        @(posedge clk);
        #2;
        word_valid = 1'b0;
        wait_idle();

        // R9: back-to-back words
        phase_tag = "R9 back-to-back bytes";
        @(posedge clk);
        #2;
        send_word(32'h01234567);
        send_word(32'h89ABCDEF);
        send_word(32'h00FF00FF);
        wait_idle();

        // R4: random words under random backpressure
        ready_mode = 2;
        phase_tag  = "R4 random order";
        for (int n = 0; n < 20; n++) begin
            @(posedge clk);
            #2;
            send_word($urandom);
        end
        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule